// File: doc/BRIEF.md
# Device Error Signaling Gate

This block sits at the error detection point of a link function and decides, for each detected error, which status bits to set, whether the error's header should be captured, and whether an error message leaves the function and with which severity. An event arrives as a one-hot bit vector, a flag that selects the correctable or uncorrectable field, and a flag that marks an uncorrectable error as a candidate for advisory treatment. The decision uses the function's reporting enables, the command-level system-error enable, the correctable mask, the uncorrectable mask and the uncorrectable severity register.

An emitted message is then walked through a parameterized chain of bridge or port levels toward the root. Each level can block the message, and for uncorrectable messages it records a received-system-error and a signaled-system-error event. All outputs are single-cycle set pulses. The registers that hold status sit outside this block and OR these pulses in. Header storage is also outside the block and acts on `log_req`.

Top module: `err_signal_gate`

## Requirements
- R1: An event is accepted only when `evt_valid` is high, `evt_bits` has exactly one bit set and, for a correctable event, that bit lies below COR_W. Every output is a pulse registered exactly one cycle after the accepted event. In a cycle with no accepted event, all outputs are zero in the next cycle.
- R2: A correctable event sets `dsta_set` bit 0 and copies its bit into `cor_sta_set`. A message of severity 2'b01 is emitted only if that bit is clear in `cor_mask` and `ctl_cor_en` is high.
- R3: An uncorrectable event always copies its bit into `unc_sta_set`. It is fatal when the same bit is set in `unc_sev`. A fatal event sets `dsta_set` bit 2 and a non-fatal event sets `dsta_set` bit 1, except on the advisory path of R8.
- R4: An uncorrectable event whose bit is set in `unc_mask` raises neither `log_req` nor a message.
- R5: An unmasked uncorrectable event that is not on the advisory path raises `log_req`, with `log_bits` equal to the event bit.
- R6: A fatal message (severity 2'b11) requires `cmd_serr_en` or `ctl_fatal_en`. A non-fatal message (2'b10) requires `cmd_serr_en` or `ctl_nf_en`.
- R7: The unsupported-request error is uncorrectable bit UR_IDX (default 20). It also sets `dsta_set` bit 3. Its message is suppressed unless `ctl_ur_en` or `cmd_serr_en` is set; on the advisory path only `ctl_ur_en` counts.
- R8: A non-fatal event with `evt_adv` set takes the advisory path. It sets `dsta_set` bit 0 (not bit 1) and correctable bit ADV_IDX (default 13), and still sets its bit in `unc_sta_set`. If `cor_mask[ADV_IDX]` is set, there is neither a log nor a message. Otherwise it is logged when unmasked in `unc_mask`, and a 2'b01 message is emitted when `ctl_cor_en` is set. A fatal event ignores `evt_adv`.
- R9: A message arrives at level 0. An arriving uncorrectable message sets that level's `hop_rcv_serr`. A level whose `hop_bridge_en` is low stops every message.
- R10: At a level that passes the bridge check, an uncorrectable message with `hop_serr_en` set sets `hop_sig_serr`. It moves on only if `hop_serr_en` and the level's enable for its severity are set; a correctable message needs only `hop_cor_en`. `msg_to_root` is high when the message passes every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Error event present this cycle |
| evt_corr | input | 1 | 1 = correctable field, 0 = uncorrectable field |
| evt_adv | input | 1 | Uncorrectable event may be treated as advisory |
| evt_bits | input | UNC_W | One-hot error bit |
| ctl_cor_en | input | 1 | Correctable reporting enable |
| ctl_nf_en | input | 1 | Non-fatal reporting enable |
| ctl_fatal_en | input | 1 | Fatal reporting enable |
| ctl_ur_en | input | 1 | Unsupported-request reporting enable |
| cmd_serr_en | input | 1 | Command-level system-error enable |
| cor_mask | input | COR_W | Correctable mask |
| unc_mask | input | UNC_W | Uncorrectable mask |
| unc_sev | input | UNC_W | Uncorrectable severity (1 = fatal) |
| hop_bridge_en | input | HOPS | Per-level bridge system-error enable |
| hop_serr_en | input | HOPS | Per-level system-error enable |
| hop_cor_en | input | HOPS | Per-level correctable enable |
| hop_nf_en | input | HOPS | Per-level non-fatal enable |
| hop_fatal_en | input | HOPS | Per-level fatal enable |
| dsta_set | output | 4 | Device status set: bit0 correctable, bit1 non-fatal, bit2 fatal, bit3 unsupported request |
| cor_sta_set | output | COR_W | Correctable status set pulse |
| unc_sta_set | output | UNC_W | Uncorrectable status set pulse |
| log_req | output | 1 | Request header capture |
| log_bits | output | UNC_W | Error bit to log |
| msg_valid | output | 1 | Error message emitted |
| msg_sev | output | 2 | 01 correctable, 10 non-fatal, 11 fatal |
| hop_arrive | output | HOPS | Message reached the level |
| hop_rcv_serr | output | HOPS | Received-system-error set at the level |
| hop_sig_serr | output | HOPS | Signaled-system-error set at the level |
| msg_to_root | output | 1 | Message passed all levels |

## Verification
The decision is purely combinational over one event and is registered once. A wrong path choice therefore shows at the ports in the very next cycle: a wrong status pulse, a missing or extra log request, or a wrong severity code. Errors in the level chain show as an arrival or system-error pulse one position too far or too short in the same cycle as `msg_valid`. The sweep crosses every bit position with both fields, the advisory flag, all sixteen reporting-enable combinations, the system-error enable, the per-bit mask and severity settings and varied level configurations. Each event's outputs are compared in full.

// File: rtl/errsig_pkg.sv
package errsig_pkg;
  typedef enum logic [1:0] {
    SEV_NONE  = 2'b00,
    SEV_COR   = 2'b01,
    SEV_NF    = 2'b10,
    SEV_FATAL = 2'b11
  } sev_e;

  // bit3 unsupported request, bit2 fatal, bit1 non-fatal, bit0 correctable
  typedef struct packed {
    logic ur;
    logic fatal;
    logic nf;
    logic cor;
  } dsta_t;
endpackage

// File: rtl/errsig_classify.sv
module errsig_classify #(
  parameter int COR_W  = 16,
  parameter int UNC_W  = 24,
  parameter int UR_IDX = 20
) (
  input  logic             evt_valid,
  input  logic             evt_corr,
  input  logic [UNC_W-1:0] evt_bits,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  output logic             ok,
  output logic             is_ur,
  output logic             is_fatal,
  output logic             unc_masked
);
  logic hi_clear;

  generate
    if (COR_W < UNC_W) begin : g_hi
      assign hi_clear = ~|evt_bits[UNC_W-1:COR_W];
    end else begin : g_nohi
      assign hi_clear = 1'b1;
    end
  endgenerate

  always_comb begin
    ok         = evt_valid && $onehot(evt_bits) && (!evt_corr || hi_clear);
    is_ur      = !evt_corr && evt_bits[UR_IDX];
    is_fatal   = |(evt_bits & unc_sev);
    unc_masked = |(evt_bits & unc_mask);
  end
endmodule

// File: rtl/errsig_decide.sv
module errsig_decide
  import errsig_pkg::*;
#(
  parameter int COR_W   = 16,
  parameter int UNC_W   = 24,
  parameter int ADV_IDX = 13
) (
  input  logic             ok,
  input  logic             evt_corr,
  input  logic             evt_adv,
  input  logic [UNC_W-1:0] evt_bits,
  input  logic             is_ur,
  input  logic             is_fatal,
  input  logic             unc_masked,
  input  logic [COR_W-1:0] cor_mask,
  input  logic             ctl_cor_en,
  input  logic             ctl_nf_en,
  input  logic             ctl_fatal_en,
  input  logic             ctl_ur_en,
  input  logic             cmd_serr_en,
  output dsta_t            dsta,
  output logic [COR_W-1:0] cor_set,
  output logic [UNC_W-1:0] unc_set,
  output logic             log_en,
  output logic             send,
  output sev_e             sev
);
  logic [COR_W-1:0] cor_bits;
  logic             cor_hit;
  logic             ur_blocked;

  assign cor_bits = evt_bits[COR_W-1:0];

  always_comb begin
    dsta       = '0;
    cor_set    = '0;
    unc_set    = '0;
    log_en     = 1'b0;
    send       = 1'b0;
    sev        = SEV_NONE;
    cor_hit    = |(cor_bits & cor_mask);
    ur_blocked = is_ur && !ctl_ur_en && !cmd_serr_en;
    if (ok) begin
      if (evt_corr) begin
        dsta.cor = 1'b1;
        cor_set  = cor_bits;
        if (!cor_hit && ctl_cor_en) begin
          send = 1'b1;
          sev  = SEV_COR;
        end
      end else begin
        unc_set = evt_bits;
        dsta.ur = is_ur;
        if (!is_fatal && evt_adv) begin
          dsta.cor         = 1'b1;
          cor_set[ADV_IDX] = 1'b1;
          if (!cor_mask[ADV_IDX]) begin
            log_en = !unc_masked;
            if ((!is_ur || ctl_ur_en) && ctl_cor_en) begin
              send = 1'b1;
              sev  = SEV_COR;
            end
          end
        end else begin
          dsta.fatal = is_fatal;
          dsta.nf    = !is_fatal;
          if (!unc_masked) begin
            log_en = 1'b1;
            if (!ur_blocked) begin
              if (is_fatal && (cmd_serr_en || ctl_fatal_en)) begin
                send = 1'b1;
                sev  = SEV_FATAL;
              end else if (!is_fatal && (cmd_serr_en || ctl_nf_en)) begin
                send = 1'b1;
                sev  = SEV_NF;
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/errsig_hops.sv
module errsig_hops
  import errsig_pkg::*;
#(
  parameter int HOPS = 3
) (
  input  logic            send,
  input  sev_e            sev,
  input  logic [HOPS-1:0] bridge_en,
  input  logic [HOPS-1:0] serr_en,
  input  logic [HOPS-1:0] cor_en,
  input  logic [HOPS-1:0] nf_en,
  input  logic [HOPS-1:0] fatal_en,
  output logic [HOPS-1:0] arrive,
  output logic [HOPS-1:0] rcv,
  output logic [HOPS-1:0] sig,
  output logic            to_root
);
  logic [HOPS:0] chain;
  logic          uncor;

  assign chain[0] = send;
  assign uncor    = (sev == SEV_NF) || (sev == SEV_FATAL);

  generate
    for (genvar i = 0; i < HOPS; i++) begin : g_hop
      logic through_bridge;
      logic sev_ok;
      always_comb begin
        through_bridge = chain[i] && bridge_en[i];
        case (sev)
          SEV_COR:   sev_ok = cor_en[i];
          SEV_NF:    sev_ok = nf_en[i];
          SEV_FATAL: sev_ok = fatal_en[i];
          default:   sev_ok = 1'b0;
        endcase
      end
      assign arrive[i]  = chain[i];
      assign rcv[i]     = chain[i] && uncor;
      assign sig[i]     = through_bridge && uncor && serr_en[i];
      assign chain[i+1] = through_bridge && sev_ok && (!uncor || serr_en[i]);
    end
  endgenerate

  assign to_root = chain[HOPS];
endmodule

// File: rtl/err_signal_gate.sv
module err_signal_gate
  import errsig_pkg::*;
#(
  parameter int COR_W   = 16,
  parameter int UNC_W   = 24,
  parameter int UR_IDX  = 20,
  parameter int ADV_IDX = 13,
  parameter int HOPS    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             evt_valid,
  input  logic             evt_corr,
  input  logic             evt_adv,
  input  logic [UNC_W-1:0] evt_bits,
  input  logic             ctl_cor_en,
  input  logic             ctl_nf_en,
  input  logic             ctl_fatal_en,
  input  logic             ctl_ur_en,
  input  logic             cmd_serr_en,
  input  logic [COR_W-1:0] cor_mask,
  input  logic [UNC_W-1:0] unc_mask,
  input  logic [UNC_W-1:0] unc_sev,
  input  logic [HOPS-1:0]  hop_bridge_en,
  input  logic [HOPS-1:0]  hop_serr_en,
  input  logic [HOPS-1:0]  hop_cor_en,
  input  logic [HOPS-1:0]  hop_nf_en,
  input  logic [HOPS-1:0]  hop_fatal_en,
  output logic [3:0]       dsta_set,
  output logic [COR_W-1:0] cor_sta_set,
  output logic [UNC_W-1:0] unc_sta_set,
  output logic             log_req,
  output logic [UNC_W-1:0] log_bits,
  output logic             msg_valid,
  output logic [1:0]       msg_sev,
  output logic [HOPS-1:0]  hop_arrive,
  output logic [HOPS-1:0]  hop_rcv_serr,
  output logic [HOPS-1:0]  hop_sig_serr,
  output logic             msg_to_root
);
  logic             ok, is_ur, is_fatal, unc_masked;
  dsta_t            d_dsta;
  logic [COR_W-1:0] d_cor;
  logic [UNC_W-1:0] d_unc;
  logic             d_log, d_send;
  sev_e             d_sev;
  logic [HOPS-1:0]  h_arr, h_rcv, h_sig;
  logic             h_root;

  errsig_classify #(.COR_W(COR_W), .UNC_W(UNC_W), .UR_IDX(UR_IDX)) u_cls (
    .evt_valid (evt_valid),
    .evt_corr  (evt_corr),
    .evt_bits  (evt_bits),
    .unc_mask  (unc_mask),
    .unc_sev   (unc_sev),
    .ok        (ok),
    .is_ur     (is_ur),
    .is_fatal  (is_fatal),
    .unc_masked(unc_masked)
  );

  errsig_decide #(.COR_W(COR_W), .UNC_W(UNC_W), .ADV_IDX(ADV_IDX)) u_dec (
    .ok          (ok),
    .evt_corr    (evt_corr),
    .evt_adv     (evt_adv),
    .evt_bits    (evt_bits),
    .is_ur       (is_ur),
    .is_fatal    (is_fatal),
    .unc_masked  (unc_masked),
    .cor_mask    (cor_mask),
    .ctl_cor_en  (ctl_cor_en),
    .ctl_nf_en   (ctl_nf_en),
    .ctl_fatal_en(ctl_fatal_en),
    .ctl_ur_en   (ctl_ur_en),
    .cmd_serr_en (cmd_serr_en),
    .dsta        (d_dsta),
    .cor_set     (d_cor),
    .unc_set     (d_unc),
    .log_en      (d_log),
    .send        (d_send),
    .sev         (d_sev)
  );

  errsig_hops #(.HOPS(HOPS)) u_hops (
    .send     (d_send),
    .sev      (d_sev),
    .bridge_en(hop_bridge_en),
    .serr_en  (hop_serr_en),
    .cor_en   (hop_cor_en),
    .nf_en    (hop_nf_en),
    .fatal_en (hop_fatal_en),
    .arrive   (h_arr),
    .rcv      (h_rcv),
    .sig      (h_sig),
    .to_root  (h_root)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dsta_set     <= '0;
      cor_sta_set  <= '0;
      unc_sta_set  <= '0;
      log_req      <= 1'b0;
      log_bits     <= '0;
      msg_valid    <= 1'b0;
      msg_sev      <= SEV_NONE;
      hop_arrive   <= '0;
      hop_rcv_serr <= '0;
      hop_sig_serr <= '0;
      msg_to_root  <= 1'b0;
    end else begin
      dsta_set     <= d_dsta;
      cor_sta_set  <= d_cor;
      unc_sta_set  <= d_unc;
      log_req      <= d_log;
      log_bits     <= d_log ? d_unc : '0;
      msg_valid    <= d_send;
      msg_sev      <= d_sev;
      hop_arrive   <= h_arr;
      hop_rcv_serr <= h_rcv;
      hop_sig_serr <= h_sig;
      msg_to_root  <= h_root;
    end
  end
endmodule

// File: rtl/errsig_checker.sv
module errsig_checker #(
  parameter int COR_W  = 16,
  parameter int UNC_W  = 24,
  parameter int UR_IDX = 20,
  parameter int HOPS   = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             evt_valid,
  input logic             evt_corr,
  input logic [UNC_W-1:0] evt_bits,
  input logic             ctl_cor_en,
  input logic             ctl_nf_en,
  input logic             ctl_fatal_en,
  input logic             ctl_ur_en,
  input logic             cmd_serr_en,
  input logic [UNC_W-1:0] unc_mask,
  input logic [3:0]       dsta_set,
  input logic [COR_W-1:0] cor_sta_set,
  input logic [UNC_W-1:0] unc_sta_set,
  input logic             log_req,
  input logic [UNC_W-1:0] log_bits,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic [HOPS-1:0]  hop_arrive,
  input logic [HOPS-1:0]  hop_rcv_serr,
  input logic [HOPS-1:0]  hop_sig_serr,
  input logic             msg_to_root
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !evt_valid |=> (dsta_set == 4'd0 && cor_sta_set == '0 && unc_sta_set == '0
                    && !log_req && !msg_valid));

  a_r1_bad_vector: assert property (@(posedge clk) disable iff (rst)
    (evt_valid && !$onehot(evt_bits)) |=> (dsta_set == 4'd0 && !msg_valid));

  a_r2_cor_enable: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'b01) |-> $past(ctl_cor_en));

  a_r3_one_severity: assert property (@(posedge clk) disable iff (rst)
    !(dsta_set[1] && dsta_set[2]));

  a_r4_no_masked_log: assert property (@(posedge clk) disable iff (rst)
    log_req |-> ((log_bits & $past(unc_mask)) == '0));

  a_r5_log_matches: assert property (@(posedge clk) disable iff (rst)
    log_req |-> ($onehot(log_bits) && log_bits == unc_sta_set));

  a_r6_fatal_enable: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'b11) |-> $past(cmd_serr_en || ctl_fatal_en));

  a_r6_nf_enable: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && msg_sev == 2'b10) |-> $past(cmd_serr_en || ctl_nf_en));

  a_r7_ur_enable: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && $past(evt_valid && !evt_corr && evt_bits == (UNC_W'(1) << UR_IDX)))
      |-> $past(ctl_ur_en || cmd_serr_en));

  a_r9_rcv_on_arrival: assert property (@(posedge clk) disable iff (rst)
    (hop_rcv_serr & ~hop_arrive) == '0);

  a_r10_sig_needs_rcv: assert property (@(posedge clk) disable iff (rst)
    (hop_sig_serr & ~hop_rcv_serr) == '0);

  a_r10_root_needs_msg: assert property (@(posedge clk) disable iff (rst)
    msg_to_root |-> (msg_valid && hop_arrive[0]));
endmodule

bind err_signal_gate errsig_checker #(
  .COR_W(COR_W), .UNC_W(UNC_W), .UR_IDX(UR_IDX), .HOPS(HOPS)
) u_chk (
  .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_corr(evt_corr),
  .evt_bits(evt_bits), .ctl_cor_en(ctl_cor_en), .ctl_nf_en(ctl_nf_en),
  .ctl_fatal_en(ctl_fatal_en), .ctl_ur_en(ctl_ur_en), .cmd_serr_en(cmd_serr_en),
  .unc_mask(unc_mask), .dsta_set(dsta_set), .cor_sta_set(cor_sta_set),
  .unc_sta_set(unc_sta_set), .log_req(log_req), .log_bits(log_bits),
  .msg_valid(msg_valid), .msg_sev(msg_sev), .hop_arrive(hop_arrive),
  .hop_rcv_serr(hop_rcv_serr), .hop_sig_serr(hop_sig_serr),
  .msg_to_root(msg_to_root)
);

// File: tb/err_signal_gate_bench.sv
module err_signal_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int COR_W   = 16;
  localparam int UNC_W   = 24;
  localparam int UR_IDX  = 20;
  localparam int ADV_IDX = 13;
  localparam int HOPS    = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic evt_valid = 0, evt_corr = 0, evt_adv = 0;
  logic [UNC_W-1:0] evt_bits = '0;
  logic ctl_cor_en = 0, ctl_nf_en = 0, ctl_fatal_en = 0, ctl_ur_en = 0, cmd_serr_en = 0;
  logic [COR_W-1:0] cor_mask = '0;
  logic [UNC_W-1:0] unc_mask = '0, unc_sev = '0;
  logic [HOPS-1:0] hop_bridge_en = '0, hop_serr_en = '0, hop_cor_en = '0;
  logic [HOPS-1:0] hop_nf_en = '0, hop_fatal_en = '0;
  logic [3:0] dsta_set;
  logic [COR_W-1:0] cor_sta_set;
  logic [UNC_W-1:0] unc_sta_set, log_bits;
  logic log_req, msg_valid, msg_to_root;
  logic [1:0] msg_sev;
  logic [HOPS-1:0] hop_arrive, hop_rcv_serr, hop_sig_serr;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  err_signal_gate #(.COR_W(COR_W), .UNC_W(UNC_W), .UR_IDX(UR_IDX),
                    .ADV_IDX(ADV_IDX), .HOPS(HOPS)) u_err_signal_gate (.*);

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // expected outputs, written from the requirement text
  logic [3:0]       e_dsta;
  logic [COR_W-1:0] e_cor;
  logic [UNC_W-1:0] e_unc, e_logb;
  logic             e_log, e_msg, e_root;
  logic [1:0]       e_sev;
  logic [HOPS-1:0]  e_arr, e_rcv, e_sig;
  string            t_main, t_log, t_msg, t_hop;

  task automatic model();
    logic ok, fatal, ur, umask, adv_path, cmask;
    logic here;
    e_dsta = '0; e_cor = '0; e_unc = '0; e_logb = '0; e_log = 0; e_msg = 0;
    e_sev = 2'b00; e_arr = '0; e_rcv = '0; e_sig = '0; e_root = 0;
    ok = evt_valid && ($countones(evt_bits) == 1) &&
         (!evt_corr || evt_bits[UNC_W-1:COR_W] == '0);
    fatal = |(evt_bits & unc_sev);
    ur = !evt_corr && evt_bits[UR_IDX];
    umask = |(evt_bits & unc_mask);
    adv_path = !evt_corr && !fatal && evt_adv;
    t_main = !ok ? "R1" : evt_corr ? "R2" : adv_path ? "R8" : ur ? "R7" : "R3";
    t_log = !ok ? "R1" : adv_path ? "R8" : umask ? "R4" : "R5";
    t_msg = !ok ? "R1" : evt_corr ? "R2" : adv_path ? "R8" : ur ? "R7" : "R6";
    if (ok && evt_corr) begin
      e_dsta[0] = 1;
      e_cor = evt_bits[COR_W-1:0];
      cmask = |(evt_bits[COR_W-1:0] & cor_mask);
      if (!cmask && ctl_cor_en) begin e_msg = 1; e_sev = 2'b01; end
    end else if (ok) begin
      e_unc = evt_bits;
      e_dsta[3] = ur;
      if (adv_path) begin
        e_dsta[0] = 1;
        e_cor[ADV_IDX] = 1;
        if (!cor_mask[ADV_IDX]) begin
          e_log = !umask;
          if (ctl_cor_en && (!ur || ctl_ur_en)) begin e_msg = 1; e_sev = 2'b01; end
        end
      end else begin
        e_dsta[2] = fatal;
        e_dsta[1] = !fatal;
        if (!umask) begin
          e_log = 1;
          if (!ur || ctl_ur_en || cmd_serr_en) begin
            if (fatal && (cmd_serr_en || ctl_fatal_en)) begin e_msg = 1; e_sev = 2'b11; end
            if (!fatal && (cmd_serr_en || ctl_nf_en)) begin e_msg = 1; e_sev = 2'b10; end
          end
        end
      end
    end
    if (e_log) e_logb = evt_bits;
    here = e_msg;
    t_hop = "R10";
    for (int i = 0; i < HOPS; i++) begin
      logic unc, en;
      unc = e_sev[1];
      en = (e_sev == 2'b01) ? hop_cor_en[i] : (e_sev == 2'b10) ? hop_nf_en[i] : hop_fatal_en[i];
      e_arr[i] = here;
      e_rcv[i] = here && unc;
      if (here && !hop_bridge_en[i]) t_hop = "R9";
      e_sig[i] = here && hop_bridge_en[i] && unc && hop_serr_en[i];
      here = here && hop_bridge_en[i] && en && (!unc || hop_serr_en[i]);
    end
    e_root = here;
  endtask

  task automatic compare_all();
    check(t_main, "dsta_set", 32'(dsta_set), 32'(e_dsta));
    check(t_main, "cor_sta_set", 32'(cor_sta_set), 32'(e_cor));
    check(t_main, "unc_sta_set", 32'(unc_sta_set), 32'(e_unc));
    check(t_log, "log", {7'd0, log_req, log_bits}, {7'd0, e_log, e_logb});
    check(t_msg, "msg", {30'd0, msg_valid, msg_sev != 2'b00 ? msg_sev : 2'b00} >> 0,
          {30'd0, e_msg, e_sev} >> 0);
    check(t_hop, "hops", {20'd0, msg_to_root, hop_arrive, hop_rcv_serr, hop_sig_serr},
          {20'd0, e_root, e_arr, e_rcv, e_sig});
  endtask

  task automatic quiet_check(input string what);
    check("R1", what, {dsta_set, cor_sta_set, 2'b00, log_req, msg_valid, msg_to_root},
          '0);
    check("R1", {what, " unc"}, 32'(unc_sta_set), '0);
  endtask

  // one event: drive at a falling edge, compare at the next falling edge
  task automatic run_event();
    model();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    repeat (3) @(negedge clk);
    quiet_check("reset state");
    rst = 0;
    @(negedge clk);
    quiet_check("idle after reset");

    // invalid vectors (R1): zero bits, two bits, correctable above field
    ctl_cor_en = 1; ctl_nf_en = 1; ctl_fatal_en = 1; cmd_serr_en = 1;
    evt_valid = 1; evt_corr = 0; evt_bits = '0;
    run_event();
    evt_bits = 24'h000011;
    run_event();
    evt_corr = 1; evt_bits = 24'h100000;
    run_event();
    evt_valid = 0; evt_corr = 0; evt_bits = 24'h000001;
    run_event();

    for (int idx = 0; idx < UNC_W; idx++)
      for (int c = 0; c < 2; c++)
        for (int a = 0; a < 2; a++)
          for (int ctl = 0; ctl < 16; ctl++)
            for (int s = 0; s < 2; s++)
              for (int m = 0; m < 2; m++)
                for (int sv = 0; sv < 2; sv++)
                  for (int am = 0; am < 2; am++) begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    evt_valid = 1;
                    evt_corr = c[0];
                    evt_adv = a[0];
                    evt_bits = UNC_W'(1) << idx;
                    {ctl_ur_en, ctl_fatal_en, ctl_nf_en, ctl_cor_en} = ctl[3:0];
                    cmd_serr_en = s[0];
                    unc_mask = (m[0] ? (UNC_W'(1) << idx) : '0) |
                               (UNC_W'(1) << ((idx + 1) % UNC_W));
                    unc_sev = (sv[0] ? (UNC_W'(1) << idx) : '0) |
                              (UNC_W'(1) << ((idx + 2) % UNC_W));
                    cor_mask = '0;
                    if (m[0] && idx < COR_W) cor_mask[idx] = 1'b1;
                    cor_mask[ADV_IDX] = am[0];
                    cor_mask[(idx + 3) % COR_W] = 1'b1;
                    if (m[0] && idx < COR_W) cor_mask[idx] = 1'b1;
                    else if (idx < COR_W && ((idx + 3) % COR_W) != idx) cor_mask[idx] = 1'b0;
                    hop_bridge_en = lfsr[2:0] | lfsr[5:3];
                    hop_serr_en = lfsr[8:6] | lfsr[11:9];
                    hop_cor_en = lfsr[14:12] | 3'b001;
                    hop_nf_en = lfsr[3:1] | lfsr[12:10];
                    hop_fatal_en = lfsr[6:4] | lfsr[15:13];
                    run_event();
                  end

    evt_valid = 0;
    @(negedge clk);
    quiet_check("idle after sweep");
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule